// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a free-running watchdog. Once armed, it counts a 12-bit value down to zero at a rate set by a power-of-two clock divider. When that count runs out, it raises a one-cycle reset request toward the system. Software reaches the block through a small word-addressed register port. A key register takes 16-bit codes. One code opens the divider, reload and window registers for writing. Another arms the counter. A third refreshes the count. Once armed, the watchdog cannot be disarmed except by the block's own reset.

New divider and reload values do not act at once. Each accepted write holds a busy flag in the status register for a fixed number of cycles, which models a crossing into a slower clock. The new value takes effect only when that flag drops. A window value makes refreshes that come too early into a fault: a refresh while the count is still above the window raises the reset request instead of restarting the count.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the divider register reads 0, the reload register reads 0xFFF, the window register reads 0xFFF, status reads 0, and `wdg_rst_req` stays low while the counter is not armed.
- R2: Writing 0x5555 in bits [15:0] at offset 0x00 unlocks the divider, reload and window registers. Any other key value locks them again. Writes to offsets 0x04, 0x08 or 0x10 while locked leave their readback unchanged. The key offset and unmapped offsets read 0.
- R3: Divider code bits [2:0] at offset 0x04 select division by 4 shifted left by the code. Codes 6 and 7 both give 256. The reload value sits in bits [11:0] at offset 0x08. Readback shows a written value on the next cycle.
- R4: Status offset 0x0C bit 0 (divider busy) and bit 1 (reload busy) read 1 for exactly 5 cycles after an accepted write, counted from the write edge. A rewrite during that time restarts the 5 cycles. The new value takes effect when the bit clears.
- R5: Key 0xCCCC arms the counter. `wdg_rst_req` is high for exactly one cycle, first at (reload+1)×divider cycles after the arming write and then again each (reload+1)×divider cycles.
- R6: Once armed, neither a lock key nor a second 0xCCCC stops or restarts the counter.
- R7: Key 0xAAAA, given while armed and while the count is at or below the window, restarts the count from the reload value and clears the divider phase. The next request comes (reload+1)×divider cycles after the refresh. The same key given while not armed has no effect.
- R8: Key 0xAAAA, given while the count is above the window, raises `wdg_rst_req` in the next cycle and leaves the running count untouched.
- R9: When a valid refresh lands on the same edge as an expiry, the refresh wins and no request is raised.
- R10: The window value sits in bits [11:0] at offset 0x10 and acts as soon as it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; the only way to disarm |
| bus_we | input | 1 | Write strobe for one word |
| bus_addr | input | ADDR_W (5) | Byte offset of the accessed word |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| wdg_rst_req | output | 1 | One-cycle reset request |

## Verification
A refresh key and a prescaler tick that finds the count at zero can arrive on the same clock edge. The bench arms the counter with a small reload value and counts edges from the arming write. It then places the 0xAAAA write exactly on the expiry edge. The run passes only if no request appears on that edge and the next request comes a full period after the refresh. A second case times a refresh that comes too early against a running count, and checks that the fault pulse appears while the count's own expiry edge does not move.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   localparam logic [15:0] KEY_OPEN  = 16'h5555;
   localparam logic [15:0] KEY_ARM   = 16'hCCCC;
   localparam logic [15:0] KEY_FEED  = 16'hAAAA;

   localparam logic [2:0] WIDX_KEY = 3'd0;
   localparam logic [2:0] WIDX_DIV = 3'd1;
   localparam logic [2:0] WIDX_RLD = 3'd2;
   localparam logic [2:0] WIDX_STS = 3'd3;
   localparam logic [2:0] WIDX_WIN = 3'd4;

   typedef enum logic [2:0] {
      SEL_KEY, SEL_DIV, SEL_RLD, SEL_STS, SEL_WIN, SEL_NONE
   } kwd_sel_e;
endpackage

// File: rtl/kwd_sync_reg.sv
module kwd_sync_reg #(
   parameter int          W       = 12,
   parameter int          DLY     = 5,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_val,
   output logic [W-1:0] shadow_o,
   output logic [W-1:0] active_o,
   output logic         busy_o
);
   generate
      if (DLY < 0) begin : g_bad_dly
         initial $fatal(1, "kwd_sync_reg: DLY must not be negative");
      end
      if (DLY == 0) begin : g_direct
         logic [W-1:0] val_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     val_q <= RST_VAL;
            else if (wr_en) val_q <= wr_val;
         end
         assign shadow_o = val_q;
         assign active_o = val_q;
         assign busy_o   = 1'b0;
      end else begin : g_delayed
         localparam int TW = $clog2(DLY + 1);
         logic [TW-1:0] tmr_q;
         logic [W-1:0]  shd_q;
         logic [W-1:0]  act_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tmr_q <= '0;
               shd_q <= RST_VAL;
               act_q <= RST_VAL;
            end else begin
               if (wr_en) begin
                  shd_q <= wr_val;
                  tmr_q <= TW'(DLY);
               end else if (tmr_q != '0) begin
                  tmr_q <= tmr_q - 1'b1;
               end
               if (!wr_en && tmr_q == TW'(1)) act_q <= shd_q;
            end
         end
         assign shadow_o = shd_q;
         assign active_o = act_q;
         assign busy_o   = (tmr_q != '0);
      end
   endgenerate
endmodule

// File: rtl/kwd_regfile.sv
module kwd_regfile
   import kwd_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 12,
   parameter int PR_W     = 3,
   parameter int SYNC_DLY = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [PR_W-1:0]   div_code_o,
   output logic [CNT_W-1:0]  reload_o,
   output logic [CNT_W-1:0]  window_o,
   output logic              arm_o,
   output logic              feed_o,
   output logic              open_o,
   output logic [1:0]        busy_o
);
   kwd_sel_e         sel;
   logic             open_q;
   logic             key_wr;
   logic [15:0]      key_val;
   logic [CNT_W-1:0] win_q;
   logic [PR_W-1:0]  div_shadow;
   logic [CNT_W-1:0] rld_shadow;
   logic             div_wr;
   logic             rld_wr;
   logic             win_wr;
   logic             unused_bits;

   assign unused_bits = ^bus_wdata[DATA_W-1:16];
   assign key_val     = bus_wdata[15:0];

   always_comb begin
      sel = SEL_NONE;
      if (bus_addr[1:0] == 2'b00 && (bus_addr >> 5) == '0) begin
         case (bus_addr[4:2])
            WIDX_KEY: sel = SEL_KEY;
            WIDX_DIV: sel = SEL_DIV;
            WIDX_RLD: sel = SEL_RLD;
            WIDX_STS: sel = SEL_STS;
            WIDX_WIN: sel = SEL_WIN;
            default:  sel = SEL_NONE;
         endcase
      end
   end

   assign key_wr = bus_we && sel == SEL_KEY;
   assign div_wr = bus_we && sel == SEL_DIV && open_q;
   assign rld_wr = bus_we && sel == SEL_RLD && open_q;
   assign win_wr = bus_we && sel == SEL_WIN && open_q;
   assign arm_o  = key_wr && key_val == KEY_ARM;
   assign feed_o = key_wr && key_val == KEY_FEED;
   assign open_o = open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         win_q  <= '1;
      end else begin
         if (key_wr) open_q <= (key_val == KEY_OPEN);
         if (win_wr) win_q  <= bus_wdata[CNT_W-1:0];
      end
   end
   assign window_o = win_q;

   kwd_sync_reg #(.W(PR_W), .DLY(SYNC_DLY), .RST_VAL('0)) u_div (
      .clk(clk), .rst_n(rst_n), .wr_en(div_wr), .wr_val(bus_wdata[PR_W-1:0]),
      .shadow_o(div_shadow), .active_o(div_code_o), .busy_o(busy_o[0])
   );

   kwd_sync_reg #(.W(CNT_W), .DLY(SYNC_DLY), .RST_VAL('1)) u_rld (
      .clk(clk), .rst_n(rst_n), .wr_en(rld_wr), .wr_val(bus_wdata[CNT_W-1:0]),
      .shadow_o(rld_shadow), .active_o(reload_o), .busy_o(busy_o[1])
   );

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_DIV: bus_rdata[PR_W-1:0]  = div_shadow;
         SEL_RLD: bus_rdata[CNT_W-1:0] = rld_shadow;
         SEL_STS: bus_rdata[1:0]       = busy_o;
         SEL_WIN: bus_rdata[CNT_W-1:0] = win_q;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
   parameter int PR_W        = 3,
   parameter int MAX_PR_CODE = 6,
   parameter int PRE_W       = MAX_PR_CODE + 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            clr,
   input  logic [PR_W-1:0] code,
   output logic            tick
);
   logic [PR_W-1:0]  sh;
   logic [PRE_W:0]   div_full;
   logic [PRE_W-1:0] lim;
   logic [PRE_W-1:0] pre_q;

   always_comb begin
      sh       = (code > PR_W'(MAX_PR_CODE)) ? PR_W'(MAX_PR_CODE) : code;
      div_full = (PRE_W + 1)'(4) << sh;
      lim      = PRE_W'(div_full - 1'b1);
   end

   assign tick = run && (pre_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre_q <= '0;
      else if (clr)    pre_q <= '0;
      else if (run)    pre_q <= (pre_q >= lim) ? '0 : pre_q + 1'b1;
   end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             feed,
   input  logic             tick,
   input  logic [CNT_W-1:0] reload_val,
   input  logic [CNT_W-1:0] window_val,
   output logic             run_o,
   output logic             pre_clr_o,
   output logic             req_o
);
   logic             run_q;
   logic             req_q;
   logic [CNT_W-1:0] cnt_q;
   logic             feed_ok;
   logic             feed_early;

   assign feed_ok    = run_q && feed && (cnt_q <= window_val);
   assign feed_early = run_q && feed && (cnt_q >  window_val);
   assign pre_clr_o  = (arm && !run_q) || feed_ok;
   assign run_o      = run_q;
   assign req_o      = req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         req_q <= 1'b0;
      end else begin
         req_q <= 1'b0;
         if (!run_q) begin
            if (arm) begin
               run_q <= 1'b1;
               cnt_q <= reload_val;
            end
         end else if (feed_ok) begin
            cnt_q <= reload_val;
         end else begin
            if (feed_early) req_q <= 1'b1;
            if (tick) begin
               if (cnt_q == '0) begin
                  req_q <= 1'b1;
                  cnt_q <= reload_val;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 12,
   parameter int PR_W        = 3,
   parameter int MAX_PR_CODE = 6,
   parameter int SYNC_DLY    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wdg_rst_req
);
   localparam int PRE_W = MAX_PR_CODE + 2;

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         initial $fatal(1, "keyed_watchdog: ADDR_W must be at least 5");
      end
      if (DATA_W < 16 || CNT_W > DATA_W || CNT_W < 1) begin : g_bad_data
         initial $fatal(1, "keyed_watchdog: DATA_W/CNT_W out of range");
      end
      if (MAX_PR_CODE > (1 << PR_W) - 1) begin : g_bad_pr
         initial $fatal(1, "keyed_watchdog: MAX_PR_CODE exceeds code field");
      end
   endgenerate

   logic [PR_W-1:0]  act_div_w;
   logic [CNT_W-1:0] act_rld_w;
   logic [CNT_W-1:0] win_w;
   logic             arm_w;
   logic             feed_w;
   logic             unlock_w;
   logic [1:0]       busy_w;
   logic             tick_w;
   logic             run_w;
   logic             pre_clr_w;

   kwd_regfile #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PR_W(PR_W), .SYNC_DLY(SYNC_DLY)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .div_code_o(act_div_w),
      .reload_o(act_rld_w), .window_o(win_w), .arm_o(arm_w), .feed_o(feed_w),
      .open_o(unlock_w), .busy_o(busy_w)
   );

   kwd_prescaler #(.PR_W(PR_W), .MAX_PR_CODE(MAX_PR_CODE), .PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_w), .clr(pre_clr_w),
      .code(act_div_w), .tick(tick_w)
   );

   kwd_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .arm(arm_w), .feed(feed_w), .tick(tick_w),
      .reload_val(act_rld_w), .window_val(win_w), .run_o(run_w),
      .pre_clr_o(pre_clr_w), .req_o(wdg_rst_req)
   );
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
   parameter int PR_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req,
   input logic            run,
   input logic            unlocked,
   input logic [1:0]      busy,
   input logic [PR_W-1:0] act_div
);
   // R6: an armed counter stays armed until reset
   assert_run_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> run);

   // R5: a request is only raised by an armed counter
   assert_req_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> run);

   // R2: divider busy can only start from an unlocked state
   assert_div_busy_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[0]) |-> $past(unlocked));

   // R2: reload busy can only start from an unlocked state
   assert_rld_busy_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[1]) |-> $past(unlocked));

   // R4: the divider in use holds while its update is still pending
   assert_div_hold_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[0] && $past(busy[0])) |-> $stable(act_div));
endmodule

bind keyed_watchdog kwd_checker #(.PR_W(PR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req(wdg_rst_req), .run(run_w),
   .unlocked(unlock_w), .busy(busy_w), .act_div(act_div_w)
);

// File: tb/tb_keyed_watchdog.sv
`timescale 1ns/1ps
module tb_keyed_watchdog;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wdg_rst_req;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int t_w = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   keyed_watchdog dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdg_rst_req(wdg_rst_req)
   );

   // [41:38] requirement, [37] write, [36:32] offset, [31:16] data, [15:0] expected
   localparam int NV = 27;
   localparam logic [41:0] VEC [0:NV-1] = '{
      {4'd1,  1'b0, 5'h04, 16'h0000, 16'h0000},
      {4'd1,  1'b0, 5'h08, 16'h0000, 16'h0FFF},
      {4'd1,  1'b0, 5'h10, 16'h0000, 16'h0FFF},
      {4'd1,  1'b0, 5'h0C, 16'h0000, 16'h0000},
      {4'd2,  1'b1, 5'h04, 16'h0005, 16'h0000},
      {4'd2,  1'b0, 5'h04, 16'h0000, 16'h0000},
      {4'd2,  1'b1, 5'h00, 16'h5555, 16'h0000},
      {4'd3,  1'b1, 5'h04, 16'h0005, 16'h0000},
      {4'd3,  1'b0, 5'h04, 16'h0000, 16'h0005},
      {4'd3,  1'b1, 5'h08, 16'h0123, 16'h0000},
      {4'd3,  1'b0, 5'h08, 16'h0000, 16'h0123},
      {4'd10, 1'b1, 5'h10, 16'h0456, 16'h0000},
      {4'd10, 1'b0, 5'h10, 16'h0000, 16'h0456},
      {4'd2,  1'b1, 5'h00, 16'h1234, 16'h0000},
      {4'd2,  1'b1, 5'h08, 16'h0077, 16'h0000},
      {4'd2,  1'b0, 5'h08, 16'h0000, 16'h0123},
      {4'd2,  1'b1, 5'h10, 16'h0001, 16'h0000},
      {4'd2,  1'b0, 5'h10, 16'h0000, 16'h0456},
      {4'd2,  1'b1, 5'h00, 16'h5555, 16'h0000},
      {4'd3,  1'b1, 5'h04, 16'h0007, 16'h0000},
      {4'd3,  1'b0, 5'h04, 16'h0000, 16'h0007},
      {4'd2,  1'b1, 5'h00, 16'h0000, 16'h0000},
      {4'd2,  1'b1, 5'h04, 16'h0002, 16'h0000},
      {4'd2,  1'b0, 5'h04, 16'h0000, 16'h0007},
      {4'd2,  1'b0, 5'h00, 16'h0000, 16'h0000},
      {4'd2,  1'b0, 5'h14, 16'h0000, 16'h0000},
      {4'd2,  1'b0, 5'h06, 16'h0000, 16'h0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      bus_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1;
      bus_addr = a;
      bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
      t_w = cyc;
   endtask

   task automatic peek(input logic [4:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic setup(input int pr, input int rl, input int win);
      logic [31:0] s;
      wr(5'h00, 32'h5555);
      wr(5'h04, pr);
      wr(5'h08, rl);
      wr(5'h10, win);
      wr(5'h00, 32'h0000);
      for (int i = 0; i < 50; i++) begin
         peek(5'h0C, s);
         if (s == 0) break;
         @(negedge clk);
      end
   endtask

   task automatic wait_pulse(output int t);
      t = -1;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (wdg_rst_req) begin
            t = cyc;
            break;
         end
      end
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      int ts, p1, p2, hi;
      do_reset();

      // R1: idle, no request
      hi = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (wdg_rst_req) hi++;
      end
      chk("R1 idle request count", hi, 0);

      // Register access table (R1, R2, R3, R10)
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][37]) begin
            wr(VEC[i][36:32], {16'h0, VEC[i][31:16]});
         end else begin
            @(negedge clk);
            peek(VEC[i][36:32], v);
            chk($sformatf("R%0d vector %0d", VEC[i][41:38], i), v, {16'h0, VEC[i][15:0]});
         end
      end

      // R4: busy timing and restart
      do_reset();
      wr(5'h00, 32'h5555);
      wr(5'h04, 32'h2);
      peek(5'h0C, v); chk("R4 div busy k0", v, 32'h1);
      repeat (4) @(negedge clk);
      peek(5'h0C, v); chk("R4 div busy k4", v, 32'h1);
      @(negedge clk);
      peek(5'h0C, v); chk("R4 div busy k5", v, 32'h0);
      wr(5'h08, 32'h5);
      wr(5'h08, 32'h6);
      peek(5'h08, v); chk("R4 reload readback", v, 32'h6);
      repeat (4) @(negedge clk);
      peek(5'h0C, v); chk("R4 reload busy restarted", v, 32'h2);
      @(negedge clk);
      peek(5'h0C, v); chk("R4 reload busy cleared", v, 32'h0);

      // R5: period with divider 4, reload 3
      do_reset();
      setup(0, 3, 12'hFFF);
      wr(5'h00, 32'hCCCC); ts = t_w;
      wait_pulse(p1);
      chk("R5 first request", p1 - ts, 16);
      @(negedge clk);
      chk("R5 one cycle wide", wdg_rst_req, 0);
      wait_pulse(p2);
      chk("R5 repeat period", p2 - p1, 16);

      // R3: divider 8, reload 2
      do_reset();
      setup(1, 2, 12'hFFF);
      wr(5'h00, 32'hCCCC); ts = t_w;
      wait_pulse(p1);
      chk("R3 divide by 8", p1 - ts, 24);

      // R3: code 7 saturates at 256
      do_reset();
      setup(7, 0, 12'hFFF);
      wr(5'h00, 32'hCCCC); ts = t_w;
      wait_pulse(p1);
      chk("R3 code 7 divides by 256", p1 - ts, 256);

      // R6: lock key and second arm do not stop or restart
      do_reset();
      setup(0, 3, 12'hFFF);
      wr(5'h00, 32'hCCCC); ts = t_w;
      wr(5'h00, 32'h0000);
      wr(5'h00, 32'hCCCC);
      wait_pulse(p1);
      chk("R6 not restarted", p1 - ts, 16);
      wait_pulse(p2);
      chk("R6 still running", p2 - ts, 32);

      // R7: valid refresh restarts period
      do_reset();
      setup(0, 3, 12'hFFF);
      wr(5'h00, 32'hCCCC); ts = t_w;
      wait_until(ts + 8);
      wr(5'h00, 32'hAAAA);
      wait_pulse(p1);
      chk("R7 refresh restarts", p1 - t_w, 16);

      // R7: refresh while not armed has no effect
      do_reset();
      wr(5'h00, 32'hAAAA);
      hi = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (wdg_rst_req) hi++;
      end
      chk("R7 idle refresh ignored", hi, 0);

      // R8 / R10: early refresh faults, count continues
      do_reset();
      setup(0, 3, 1);
      wr(5'h00, 32'hCCCC); ts = t_w;
      wr(5'h00, 32'hAAAA);
      chk("R8 early refresh request", wdg_rst_req, 1);
      @(negedge clk);
      chk("R8 early request one cycle", wdg_rst_req, 0);
      wait_pulse(p1);
      chk("R8 count untouched", p1 - ts, 16);
      wait_until(ts + 27);
      wr(5'h00, 32'hAAAA);
      chk("R10 in-window refresh no request", wdg_rst_req, 0);
      wait_pulse(p2);
      chk("R10 in-window refresh restarts", p2 - ts, 45);

      // R9: refresh on the expiry edge wins
      do_reset();
      setup(0, 3, 12'hFFF);
      wr(5'h00, 32'hCCCC); ts = t_w;
      wait_until(ts + 14);
      wr(5'h00, 32'hAAAA);
      chk("R9 refresh edge placement", t_w - ts, 16);
      chk("R9 no request on coincidence", wdg_rst_req, 0);
      wait_pulse(p1);
      chk("R9 next request", p1 - ts, 32);

      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog expired before the sequence ended");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule